// File: doc/BRIEF.md
# Equalization Phase TS0 Usage Monitor

This block is a passive protocol monitor placed beside a link training engine. Every cycle it samples the current training state code, the equalization phase number, the port role (downstream or upstream) and an optional training set indication. It decides whether a TS0 set is legal at that point and whether phases that must open with TS0 actually do so. Generating and decoding the sets is left to other logic.

TS0 sets are legal only while the link is in the recovery equalization state. In that state a downstream port may use them only in phases 1 and 2, and an upstream port may use them in any phase. Two phases must open with TS0 and then move to TS1: phase 2 for a downstream port and phase 3 for an upstream port. Each violation raises a one-cycle registered pulse with a code. A sticky vector keeps a record of every violation until software-independent logic clears it through a clear input.

Top module: `eq_ts0_monitor`

## Requirements
- R1: A TS0 indication (set_type 0) while state differs from the equalization state code produces err_pulse with err_code 1 on the following cycle.
- R2: In the equalization state a downstream port (role_down=1) may send TS0 in phases 1 and 2 without error; a TS0 in phase 0 or 3 produces err_code 2.
- R3: In the equalization state an upstream port (role_down=0) may send TS0 in any phase 0 to 3; the monitor raises no error for it unless R6 applies.
- R4: In a lead phase (downstream phase 2, upstream phase 3), a TS0 followed by TS1 sets raises no error.
- R5: In a lead phase, a TS1 (set_type 1) arriving before any TS0 produces err_code 4, once per phase; later TS1 sets in the same phase raise nothing.
- R6: In a lead phase, a TS0 arriving after a TS1 of the same phase produces err_code 3.
- R7: A change of state code, phase number or role clears the lead-phase order tracking, so the next phase visit is judged from scratch.
- R8: err_pulse is high for exactly one cycle per violating indication, the cycle after it is sampled; err_code is 0 whenever err_pulse is low. Code 1 takes priority over 2, and 2 over 3.
- R9: Error code k sets bit k-1 of err_sticky on the same cycle as the pulse; the bit holds until clr_sticky is sampled high. A new error sampled in the same cycle as clr_sticky leaves only its own bit set.
- R10: TS2 (set_type 2) and other sets (set_type 3) never raise an error and do not count as the first set of a lead phase.
- R11: While rst is high, err_pulse, err_code and err_sticky are all zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state | input | STATE_W | Current link training state code |
| phase | input | PHASE_W | Current equalization phase number |
| role_down | input | 1 | 1 = downstream port, 0 = upstream port |
| set_valid | input | 1 | A training set indication is present this cycle |
| set_type | input | 2 | 0 TS0, 1 TS1, 2 TS2, 3 other |
| clr_sticky | input | 1 | Clears the sticky error record |
| err_pulse | output | 1 | One-cycle violation strobe |
| err_code | output | 3 | Code of the violation, 0 when idle |
| err_sticky | output | 4 | Sticky record, bit k-1 for code k |

## Verification
A stale order tracker shows at the ports as a false code 3 or code 4, or a missing one, on the first set of a revisited lead phase, one cycle after that set is sampled. A wrong legality decision shows as a wrong err_code in the cycle after the offending set, and a sticky bit that fails to set or clear is visible in err_sticky in the very next cycle. The directed scenarios therefore pair each phase change with the first set that follows it and read err_sticky before and after every clear.

// File: rtl/eqmon_pkg.sv
package eqmon_pkg;
  typedef enum logic [1:0] {
    SET_TS0   = 2'd0,
    SET_TS1   = 2'd1,
    SET_TS2   = 2'd2,
    SET_OTHER = 2'd3
  } set_kind_e;

  localparam int CODE_W  = 3;
  localparam int NUM_ERR = 4;

  typedef logic [CODE_W-1:0]  err_code_t;
  typedef logic [NUM_ERR-1:0] err_vec_t;

  localparam err_code_t ERR_NONE      = 3'd0;
  localparam err_code_t ERR_OUTSIDE   = 3'd1;
  localparam err_code_t ERR_DSP_PHASE = 3'd2;
  localparam err_code_t ERR_ORDER     = 3'd3;
  localparam err_code_t ERR_NO_LEAD   = 3'd4;

  function automatic err_vec_t code_to_vec(input err_code_t code);
    err_vec_t v;
    v = '0;
    for (int i = 0; i < NUM_ERR; i++) begin
      if (int'(code) == i + 1) v[i] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/eqmon_phase_track.sv
module eqmon_phase_track #(
  parameter int STATE_W = 5,
  parameter int PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state,
  input  logic [PHASE_W-1:0] phase,
  input  logic               role_down,
  input  logic               ev_ts0,
  input  logic               ev_ts1,
  output logic               ts0_seen,
  output logic               ts1_seen
);
  logic [STATE_W-1:0] prev_state;
  logic [PHASE_W-1:0] prev_phase;
  logic               prev_role;
  logic               prev_ok;
  logic               fresh;
  logic               ts0_q, ts1_q;

  // A new context starts whenever any of the three inputs moves.
  always_comb begin
    fresh = !prev_ok || (state != prev_state) ||
            (phase != prev_phase) || (role_down != prev_role);
  end

  assign ts0_seen = fresh ? 1'b0 : ts0_q;
  assign ts1_seen = fresh ? 1'b0 : ts1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_state <= '0;
      prev_phase <= '0;
      prev_role  <= 1'b0;
      prev_ok    <= 1'b0;
      ts0_q      <= 1'b0;
      ts1_q      <= 1'b0;
    end else begin
      prev_state <= state;
      prev_phase <= phase;
      prev_role  <= role_down;
      prev_ok    <= 1'b1;
      ts0_q      <= ts0_seen | ev_ts0;
      ts1_q      <= ts1_seen | ev_ts1;
    end
  end

  // R7: a context change wipes the tracker as seen on the next cycle
  p_ctx_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && phase != prev_phase && !ev_ts0 && !ev_ts1)
      |=> (!ts0_q && !ts1_q));
endmodule

// File: rtl/eqmon_rule_eval.sv
module eqmon_rule_eval
  import eqmon_pkg::*;
#(
  parameter int PHASE_W      = 2,
  parameter int DSP_TS0_LO   = 1,
  parameter int DSP_TS0_HI   = 2,
  parameter int DSP_LEAD_PH  = 2,
  parameter int USP_LEAD_PH  = 3
) (
  input  logic               in_eq,
  input  logic               role_down,
  input  logic [PHASE_W-1:0] phase,
  input  logic               set_valid,
  input  set_kind_e          kind,
  input  logic               ts0_seen,
  input  logic               ts1_seen,
  output logic               lead_req,
  output logic               err_valid,
  output err_code_t          err_code
);
  localparam logic [PHASE_W-1:0] PH_LO   = PHASE_W'(DSP_TS0_LO);
  localparam logic [PHASE_W-1:0] PH_HI   = PHASE_W'(DSP_TS0_HI);
  localparam logic [PHASE_W-1:0] PH_DLED = PHASE_W'(DSP_LEAD_PH);
  localparam logic [PHASE_W-1:0] PH_ULED = PHASE_W'(USP_LEAD_PH);

  logic dsp_ts0_ok;

  always_comb begin
    dsp_ts0_ok = (phase >= PH_LO) && (phase <= PH_HI);
    lead_req   = in_eq && (role_down ? (phase == PH_DLED) : (phase == PH_ULED));
    err_code   = ERR_NONE;
    if (set_valid) begin
      unique case (kind)
        SET_TS0: begin
          if (!in_eq)                      err_code = ERR_OUTSIDE;
          else if (role_down && !dsp_ts0_ok) err_code = ERR_DSP_PHASE;
          else if (lead_req && ts1_seen)   err_code = ERR_ORDER;
        end
        SET_TS1: begin
          if (lead_req && !ts0_seen && !ts1_seen) err_code = ERR_NO_LEAD;
        end
        default: err_code = ERR_NONE;
      endcase
    end
    err_valid = (err_code != ERR_NONE);
  end

  // R10: TS2 and other sets are never classified as violations
  p_other_quiet_r10: assert final (!(set_valid && (kind == SET_TS2 || kind == SET_OTHER)) || !err_valid);
endmodule

// File: rtl/eqmon_err_report.sv
module eqmon_err_report
  import eqmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      err_valid,
  input  err_code_t err_code_in,
  input  logic      clr_sticky,
  output logic      err_pulse,
  output err_code_t err_code,
  output err_vec_t  err_sticky
);
  err_vec_t sticky_base;

  always_comb sticky_base = clr_sticky ? '0 : err_sticky;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse  <= 1'b0;
      err_code   <= ERR_NONE;
      err_sticky <= '0;
    end else begin
      err_pulse  <= err_valid;
      err_code   <= err_valid ? err_code_in : ERR_NONE;
      err_sticky <= sticky_base | (err_valid ? code_to_vec(err_code_in) : '0);
    end
  end

  // R9: sticky record holds when nothing sets or clears it
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_sticky && !err_valid) |=> $stable(err_sticky));
  // R8: idle code is zero
  p_idle_code_r8: assert property (@(posedge clk) disable iff (rst)
    !err_pulse |-> (err_code == ERR_NONE));
endmodule

// File: rtl/eq_ts0_monitor.sv
module eq_ts0_monitor
  import eqmon_pkg::*;
#(
  parameter int               STATE_W     = 5,
  parameter int               PHASE_W     = 2,
  parameter logic [STATE_W-1:0] EQ_STATE  = 5'd11,
  parameter int               DSP_TS0_LO  = 1,
  parameter int               DSP_TS0_HI  = 2,
  parameter int               DSP_LEAD_PH = 2,
  parameter int               USP_LEAD_PH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state,
  input  logic [PHASE_W-1:0] phase,
  input  logic               role_down,
  input  logic               set_valid,
  input  logic [1:0]         set_type,
  input  logic               clr_sticky,
  output logic               err_pulse,
  output logic [2:0]         err_code,
  output logic [3:0]         err_sticky
);
  set_kind_e kind;
  logic      in_eq, ev_ts0, ev_ts1;
  logic      ts0_seen, ts1_seen, lead_req, rule_err;
  err_code_t rule_code;

  always_comb begin
    kind   = set_kind_e'(set_type);
    in_eq  = (state == EQ_STATE);
    ev_ts0 = set_valid && (kind == SET_TS0);
    ev_ts1 = set_valid && (kind == SET_TS1);
  end

  eqmon_phase_track #(.STATE_W(STATE_W), .PHASE_W(PHASE_W)) u_track (
    .clk(clk), .rst(rst), .state(state), .phase(phase), .role_down(role_down),
    .ev_ts0(ev_ts0), .ev_ts1(ev_ts1), .ts0_seen(ts0_seen), .ts1_seen(ts1_seen)
  );

  eqmon_rule_eval #(
    .PHASE_W(PHASE_W), .DSP_TS0_LO(DSP_TS0_LO), .DSP_TS0_HI(DSP_TS0_HI),
    .DSP_LEAD_PH(DSP_LEAD_PH), .USP_LEAD_PH(USP_LEAD_PH)
  ) u_rules (
    .in_eq(in_eq), .role_down(role_down), .phase(phase), .set_valid(set_valid),
    .kind(kind), .ts0_seen(ts0_seen), .ts1_seen(ts1_seen),
    .lead_req(lead_req), .err_valid(rule_err), .err_code(rule_code)
  );

  eqmon_err_report u_report (
    .clk(clk), .rst(rst), .err_valid(rule_err), .err_code_in(rule_code),
    .clr_sticky(clr_sticky), .err_pulse(err_pulse), .err_code(err_code),
    .err_sticky(err_sticky)
  );

  // R1: TS0 outside equalization reported with code 1
  p_outside_eq_r1: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_type == 2'd0 && state != EQ_STATE)
      |=> (err_pulse && err_code == 3'd1));
  // R2: downstream TS0 in phase 3 reported with code 2
  p_dsp_ph3_r2: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_type == 2'd0 && state == EQ_STATE && role_down && phase == 2'd3)
      |=> (err_pulse && err_code == 3'd2));
  // R3: upstream TS0 outside its lead phase never flagged
  p_usp_free_r3: assert property (@(posedge clk) disable iff (rst)
    (set_valid && set_type == 2'd0 && state == EQ_STATE && !role_down && !lead_req)
      |=> !err_pulse);
  // R8: no pulse without an indication one cycle earlier
  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(set_valid));
endmodule

// File: tb/eq_ts0_monitor_bench.sv
module eq_ts0_monitor_bench;
  localparam logic [4:0] S_EQ    = 5'd11;
  localparam logic [4:0] S_OTHER = 5'd3;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] state;
  logic [1:0] phase;
  logic       role_down, set_valid, clr_sticky;
  logic [1:0] set_type;
  logic       err_pulse;
  logic [2:0] err_code;
  logic [3:0] err_sticky;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  eq_ts0_monitor u_eq_ts0_monitor (
    .clk(clk), .rst(rst), .state(state), .phase(phase), .role_down(role_down),
    .set_valid(set_valid), .set_type(set_type), .clr_sticky(clr_sticky),
    .err_pulse(err_pulse), .err_code(err_code), .err_sticky(err_sticky)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctx(input logic [4:0] s, input logic [1:0] p, input logic r);
    state = s; phase = p; role_down = r;
  endtask

  // Drive one set at a falling edge, check the pulse one edge later.
  task automatic send(input logic [1:0] t, input int exp_code, input string req);
    set_valid = 1'b1; set_type = t;
    @(posedge clk); @(negedge clk);
    set_valid = 1'b0;
    check({req, " pulse"}, int'(err_pulse), exp_code != 0 ? 1 : 0);
    check({req, " code"}, int'(err_code), exp_code);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic clear_sticky();
    clr_sticky = 1'b1; idle(1); clr_sticky = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; ctx(S_OTHER, 2'd0, 1'b1);
    set_valid = 1'b1; set_type = 2'd0; clr_sticky = 1'b0;
    idle(3);
    check("R11 pulse", int'(err_pulse), 0);
    check("R11 code", int'(err_code), 0);
    check("R11 sticky", int'(err_sticky), 0);
    set_valid = 1'b0; rst = 1'b0;
    idle(1);
  endtask

  task automatic t_outside_eq();
    ctx(S_OTHER, 2'd1, 1'b1); idle(1);
    send(2'd0, 1, "R1 dsp");
    idle(1);
    check("R8 one-cycle pulse", int'(err_pulse), 0);
    check("R8 idle code", int'(err_code), 0);
    ctx(S_OTHER, 2'd3, 1'b0); send(2'd0, 1, "R1 usp");
    check("R9 sticky bit0", int'(err_sticky), 1);
    clear_sticky();
    check("R9 cleared", int'(err_sticky), 0);
  endtask

  task automatic t_dsp_phases();
    ctx(S_EQ, 2'd0, 1'b1); idle(1); send(2'd0, 2, "R2 ph0");
    ctx(S_EQ, 2'd1, 1'b1); idle(1); send(2'd0, 0, "R2 ph1 ok");
    ctx(S_EQ, 2'd3, 1'b1); idle(1); send(2'd0, 2, "R2 ph3");
    check("R9 sticky bit1", int'(err_sticky), 2);
    clear_sticky();
  endtask

  task automatic t_usp_phases();
    for (int p = 0; p < 3; p++) begin
      ctx(S_EQ, 2'(p), 1'b0); idle(1);
      send(2'd0, 0, "R3 usp ts0");
      send(2'd1, 0, "R3 usp ts1");
      send(2'd0, 0, "R3 usp ts0 again");
    end
    check("R3 sticky none", int'(err_sticky), 0);
  endtask

  task automatic t_lead_ok();
    ctx(S_EQ, 2'd2, 1'b1); idle(1);
    send(2'd0, 0, "R4 dsp lead ts0");
    send(2'd0, 0, "R4 dsp ts0 repeat");
    send(2'd1, 0, "R4 dsp ts1");
    send(2'd1, 0, "R4 dsp ts1 repeat");
    ctx(S_EQ, 2'd3, 1'b0); idle(1);
    send(2'd0, 0, "R4 usp lead ts0");
    send(2'd1, 0, "R4 usp ts1");
    check("R4 sticky none", int'(err_sticky), 0);
  endtask

  task automatic t_missing_lead();
    ctx(S_EQ, 2'd3, 1'b0); ctx(S_EQ, 2'd1, 1'b0); idle(1);
    ctx(S_EQ, 2'd3, 1'b0); idle(1);
    send(2'd1, 4, "R5 usp no lead");
    send(2'd1, 0, "R5 only once");
    check("R9 sticky bit3", int'(err_sticky), 8);
    ctx(S_EQ, 2'd1, 1'b1); idle(1);
    ctx(S_EQ, 2'd2, 1'b1); idle(1);
    send(2'd1, 4, "R5 dsp no lead");
    clear_sticky();
  endtask

  task automatic t_order();
    ctx(S_EQ, 2'd1, 1'b1); idle(1);
    ctx(S_EQ, 2'd2, 1'b1); idle(1);
    send(2'd0, 0, "R6 lead");
    send(2'd1, 0, "R6 ts1");
    send(2'd0, 3, "R6 ts0 after ts1");
    check("R9 sticky bit2", int'(err_sticky), 4);
    clear_sticky();
  endtask

  task automatic t_tracker_reset();
    // TS1 seen in phase 2, then phase change and return in one step each
    ctx(S_EQ, 2'd1, 1'b1); idle(1);
    ctx(S_EQ, 2'd2, 1'b1); send(2'd0, 0, "R7 lead on entry cycle");
    send(2'd1, 0, "R7 ts1");
    ctx(S_EQ, 2'd1, 1'b1); idle(1);
    ctx(S_EQ, 2'd2, 1'b1); send(2'd0, 0, "R7 fresh after phase change");
    send(2'd1, 0, "R7 ts1 again");
    // role change clears too: usp phase 2 then dsp phase 2 needs a new lead
    ctx(S_EQ, 2'd2, 1'b0); idle(1);
    ctx(S_EQ, 2'd2, 1'b1); send(2'd1, 4, "R7 role change forgets lead");
    // state change: leave and return
    ctx(S_OTHER, 2'd2, 1'b1); idle(1);
    ctx(S_EQ, 2'd2, 1'b1); send(2'd0, 0, "R7 fresh after state change");
    clear_sticky();
  endtask

  task automatic t_other_types();
    ctx(S_OTHER, 2'd0, 1'b1); idle(1);
    send(2'd2, 0, "R10 ts2 outside");
    send(2'd3, 0, "R10 other outside");
    ctx(S_EQ, 2'd1, 1'b0); idle(1);
    ctx(S_EQ, 2'd3, 1'b0); idle(1);
    send(2'd2, 0, "R10 ts2 in lead");
    send(2'd3, 0, "R10 other in lead");
    send(2'd0, 0, "R10 ts0 still counts as first");
    send(2'd1, 0, "R10 ts1 after lead");
    check("R10 sticky none", int'(err_sticky), 0);
  endtask

  task automatic t_sticky_clear();
    ctx(S_OTHER, 2'd0, 1'b1); idle(1);
    send(2'd0, 1, "R9 set bit0");
    ctx(S_EQ, 2'd3, 1'b1); idle(1);
    send(2'd0, 2, "R9 set bit1");
    idle(3);
    check("R9 accumulate", int'(err_sticky), 3);
    // clear together with a new code 2 error: only bit1 remains
    clr_sticky = 1'b1;
    send(2'd0, 2, "R9 clear with new error");
    clr_sticky = 1'b0;
    check("R9 new wins over clear", int'(err_sticky), 2);
    clear_sticky();
    check("R9 clear", int'(err_sticky), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_outside_eq();
        t_dsp_phases();
        t_usp_phases();
        t_lead_ok();
        t_missing_lead();
        t_order();
        t_tracker_reset();
        t_other_types();
        t_sticky_clear();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule